// File: doc/BRIEF.md
# Three-Channel Saw/Square Tone Generator

This block is an expansion sound source with three identical tone channels. Software programs each channel through a small register space. A write presents a 4-bit offset, a data byte and a write strobe. Each channel holds a control byte and a 16-bit period.

A running channel counts down its period on every cycle that the CPU clock enable is high. Each time the count completes, a 4-bit phase steps forward by one. The channel turns the phase into a sawtooth or a square sample. It then masks that sample with a 4-bit AND mask.

The three channel samples are summed. When the console-audio enable is set, an external 4-bit console sample is added to the sum. The result leaves the block as a plain, continuously valid unsigned level. It feeds a converter that lies outside this block, so the output carries no handshake. The block has no back-pressure: every cycle's output is final, and a write takes effect on the clock edge where the strobe is sampled.

Top module: `tone_gen3`

## Requirements
- R1: After reset every channel is stopped with phase 0, all registers are 0, and `mix_out` equals the console term alone (0 when `console_en` is 0).
- R2: Channel k (k = 1, 2, 3) occupies offsets 4k, 4k+1 and 4k+2, which hold the control byte, the period low byte and the period high byte. A write to offset 0, 1, 2, 3, 7, 11 or 15 changes nothing.
- R3: While control bit 7 (run) is 0, the channel's phase is held at 0 and its period count is reloaded. Clearing the bit returns a running channel to phase 0 on the next edge.
- R4: With run set and a period N between 1 and 65535, the phase advances by one after every N clock-enabled cycles, counted from the first enabled cycle after run was seen set. The phase wraps from 15 to 0.
- R5: A period of 0 behaves exactly as a period of 1.
- R6: With control bit 4 at 0 (saw), the channel sample is the phase value.
- R7: With control bit 4 at 1 (square), the channel sample is 15 while phase bit 3 is 1, and 0 otherwise.
- R8: The shaped sample is bitwise ANDed with control bits 3:0 before it reaches the mix.
- R9: Control bits 6:5 have no effect on the output.
- R10: With `console_en` at 1, `console_smp` is added to the mix. With `console_en` at 0, it is excluded.
- R11: `mix_out` is the unsigned 6-bit sum of the three channel samples and the console term, and it never exceeds 60.
- R12: In a cycle with `cpu_ce` low, no channel's phase or period count moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU clock enable that paces the period counters |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 4 | Register offset |
| wr_data | input | 8 | Register write data |
| console_en | input | 1 | Adds the console sample to the mix when 1 |
| console_smp | input | 4 | External console audio sample |
| mix_out | output | 6 | Unsigned mixed level |

## Verification
Single-channel directed runs with saw and full mask show the stepping rate for several periods, including 0 and 1, and the 15-to-0 wrap. Square runs and partial masks separate shape selection from masking, and setting bits 6:5 shows those bits are ignored. Writes to unused offsets, and runs with `cpu_ce` low, confirm that nothing moves. A run with all channels at maximum, plus console toggling, exposes errors in sum width and in the console term. A long random mix of writes, enables and console samples then checks the interaction of all channels against a cycle model.

// File: rtl/tone_pkg.sv
package tone_pkg;
  parameter int SMP_W = 4;
  parameter int PER_W = 16;
  parameter int OFF_W = 4;
  parameter int DAT_W = 8;

  // slot within a channel's offset group
  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_PLO  = 2'd1;
  localparam logic [1:0] SLOT_PHI  = 2'd2;

  typedef struct packed {
    logic             run;
    logic [1:0]       spare;
    logic             square;
    logic [SMP_W-1:0] mask;
  } ch_ctrl_t;
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import tone_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [OFF_W-1:0]              wr_off,
  input  logic [DAT_W-1:0]              wr_data,
  output ch_ctrl_t [NUM_CH-1:0]         ctrl_q,
  output logic [NUM_CH-1:0][PER_W-1:0]  period_q
);
  localparam int HI_W = PER_W - DAT_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [1:0] GRP = 2'(c + 1);
    logic grp_hit;
    assign grp_hit = wr_en && (wr_off[3:2] == GRP);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[c]   <= '0;
        period_q[c] <= '0;
      end else if (grp_hit) begin
        case (wr_off[1:0])
          SLOT_CTRL: ctrl_q[c] <= ch_ctrl_t'(wr_data);
          SLOT_PLO:  period_q[c][DAT_W-1:0] <= wr_data;
          SLOT_PHI:  period_q[c][PER_W-1:DAT_W] <= wr_data[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic unmapped;
  assign unmapped = (wr_off[1:0] == 2'b11) || (wr_off[3:2] == 2'b00);

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> ($stable(ctrl_q) && $stable(period_q)));
endmodule

// File: rtl/tone_channel.sv
module tone_channel
  import tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  ch_ctrl_t         ctrl,
  input  logic [PER_W-1:0] period,
  output logic [SMP_W-1:0] sample
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] reload;
  logic [SMP_W-1:0] phase;
  logic [SMP_W-1:0] shape;

  assign reload = (period == '0) ? PER_W'(1) : period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= PER_W'(1);
      phase <= '0;
    end else if (!ctrl.run) begin
      cnt   <= reload;
      phase <= '0;
    end else if (ce) begin
      if (cnt == PER_W'(1)) begin
        cnt   <= reload;
        phase <= phase + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign shape  = ctrl.square ? {SMP_W{phase[SMP_W-1]}} : phase;
  assign sample = shape & ctrl.mask;

  assert_phase_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> (phase == '0));
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.run |=> ((phase == $past(phase)) || (phase == SMP_W'($past(phase) + 1'b1))));
  assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  assert_square_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.square |-> ((sample == '0) || (sample == ctrl.mask)));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ce) |=> ($stable(phase) && $stable(cnt)));
endmodule

// File: rtl/tone_mixer.sv
module tone_mixer
  import tone_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int MIX_W  = SMP_W + $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0][SMP_W-1:0] ch_smp,
  input  logic                         console_en,
  input  logic [SMP_W-1:0]             console_smp,
  output logic [MIX_W-1:0]             mix
);
  always_comb begin
    mix = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      mix = mix + MIX_W'(ch_smp[i]);
    end
    if (console_en) begin
      mix = mix + MIX_W'(console_smp);
    end
  end
endmodule

// File: rtl/tone_gen3.sv
module tone_gen3
  import tone_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int MIX_W = SMP_W + $clog2(NUM_CH + 1),
  localparam int MIX_MAX = (NUM_CH + 1) * ((1 << SMP_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ce,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             console_en,
  input  logic [SMP_W-1:0] console_smp,
  output logic [MIX_W-1:0] mix_out
);
  ch_ctrl_t [NUM_CH-1:0]         ctrl_q;
  logic [NUM_CH-1:0][PER_W-1:0]  period_q;
  logic [NUM_CH-1:0][SMP_W-1:0]  ch_smp;

  tone_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .period_q (period_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tone_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (cpu_ce),
      .ctrl   (ctrl_q[c]),
      .period (period_q[c]),
      .sample (ch_smp[c])
    );
  end

  tone_mixer #(.NUM_CH(NUM_CH), .MIX_W(MIX_W)) u_mix (
    .ch_smp      (ch_smp),
    .console_en  (console_en),
    .console_smp (console_smp),
    .mix         (mix_out)
  );

  assert_mix_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mix_out <= MIX_W'(MIX_MAX));
endmodule

// File: tb/sim_tone_gen3.sv
module sim_tone_gen3;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_off = '0;
  logic [7:0] wr_data = '0;
  logic       console_en = 1'b0;
  logic [3:0] console_smp = '0;
  logic [5:0] mix_out;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // model state
  logic [7:0]  m_ctrl [3];
  logic [15:0] m_per  [3];
  int          m_cnt  [3];
  int          m_ph   [3];

  always #2 clk = ~clk;

  tone_gen3 u0 (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .console_en(console_en), .console_smp(console_smp),
    .mix_out(mix_out)
  );

  function automatic int eff_per(logic [15:0] p);
    return (p == 16'd0) ? 1 : int'(p);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_ctrl[c] = '0; m_per[c] = '0; m_cnt[c] = 1; m_ph[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        if (!m_ctrl[c][7]) begin
          m_cnt[c] = eff_per(m_per[c]); m_ph[c] = 0;
        end else if (cpu_ce) begin
          if (m_cnt[c] == 1) begin
            m_cnt[c] = eff_per(m_per[c]); m_ph[c] = (m_ph[c] + 1) % 16;
          end else begin
            m_cnt[c] = m_cnt[c] - 1;
          end
        end
      end
      if (wr_en && wr_off[1:0] != 2'b11 && wr_off[3:2] != 2'b00) begin
        int c;
        c = int'(wr_off[3:2]) - 1;
        case (wr_off[1:0])
          2'd0: m_ctrl[c] = wr_data;
          2'd1: m_per[c][7:0] = wr_data;
          default: m_per[c][15:8] = wr_data;
        endcase
      end
    end
  end

  function automatic int exp_mix();
    int s = 0;
    for (int c = 0; c < 3; c++) begin
      int sh;
      if (m_ctrl[c][4]) sh = (m_ph[c] >= 8) ? 15 : 0;
      else sh = m_ph[c];
      s += sh & int'(m_ctrl[c][3:0]);
    end
    if (console_en) s += int'(console_smp);
    return s;
  endfunction

  task automatic check();
    int e;
    e = exp_mix();
    n_chk++;
    if (int'(mix_out) != e) begin
      n_bad++;
      $display("FAIL %s: mix_out actual %0d expected %0d at %0t", cur_req, mix_out, e, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic wr(logic [3:0] off, logic [7:0] d);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic setup(int ch, logic [7:0] ctrl, logic [15:0] per);
    wr(4'(4 * ch + 1), per[7:0]);
    wr(4'(4 * ch + 2), per[15:8]);
    wr(4'(4 * ch), ctrl);
  endtask

  task automatic stop_all();
    for (int c = 1; c <= 3; c++) wr(4'(4 * c), 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; step(4);
    cur_req = "R1"; console_en = 1'b1; console_smp = 4'd9; step(2);
    console_en = 1'b0; console_smp = '0;

    cpu_ce = 1'b1;
    cur_req = "R6"; setup(1, 8'h8F, 16'd3); step(60);
    cur_req = "R4"; stop_all(); setup(2, 8'h8F, 16'd7); step(130);
    cur_req = "R5"; stop_all(); setup(3, 8'h8F, 16'd0); step(40);
    cur_req = "R4"; stop_all(); setup(1, 8'h8F, 16'd1); step(40);
    cur_req = "R4"; stop_all(); setup(1, 8'h8F, 16'h0102); step(600);
    cur_req = "R7"; stop_all(); setup(2, 8'h9F, 16'd2); step(70);
    cur_req = "R8"; setup(1, 8'h85, 16'd1); setup(3, 8'h9A, 16'd1); step(40);
    cur_req = "R9"; stop_all(); setup(1, 8'hEF, 16'd2); step(40);
    cur_req = "R3"; wr(4'h4, 8'h0F); step(5); wr(4'h4, 8'h8F); step(20);

    cur_req = "R2";
    for (int k = 0; k < 16; k++) begin
      if (k[1:0] == 2'b11 || k < 4) wr(4'(k), 8'hFF);
    end
    step(20);

    cur_req = "R12"; cpu_ce = 1'b0; step(30); cpu_ce = 1'b1; step(10);
    cur_req = "R10"; console_smp = 4'd11; console_en = 1'b1; step(10);
    console_en = 1'b0; step(10);
    cur_req = "R11"; stop_all(); console_en = 1'b1; console_smp = 4'd15;
    setup(1, 8'h9F, 16'd4); setup(2, 8'h9F, 16'd4); setup(3, 8'h9F, 16'd4);
    step(80);

    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      cpu_ce = ($urandom % 4) != 0;
      console_en = $urandom % 2;
      console_smp = 4'($urandom);
      if (($urandom % 8) == 0) begin
        logic [3:0] o;
        logic [7:0] d;
        o = 4'($urandom);
        d = 8'($urandom);
        if (o[1:0] == 2'd1) d = d & 8'h07;
        if (o[1:0] == 2'd2) d = (($urandom % 8) == 0) ? 8'h01 : 8'h00;
        wr(o, d);
      end else begin
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule